// File: doc/BRIEF.md
# Staged Runtime Coefficient/Offset RAM Writer

This block lets a running signal-processing core have its coefficient RAM or its offset RAM updated without ever seeing a partly updated set of values. A prepare command names the target RAM, a 16-bit start address and a word count. The data words that follow are held in a local staging buffer. A separate commit command then copies the held words into the target RAM as one burst. The burst goes through a request/grant write port, so the core decides when the block may write.

Commands arrive already decoded from the serial front end. Each command is one 8-bit code with a 16-bit address field, and data words arrive as 24-bit values. A readback command returns any staged word, so a host can check the buffer before it commits. A commit that does not match the pending prepare raises an error and leaves the buffer as it was. A commit made before all declared words have arrived writes the words held so far and raises a short-count flag.

Top module: `staged_ram_writer`

## Requirements
- R1: A prepare command with code 0x80..0x8F stages for coefficient RAM (`ram_sel` = 0). A prepare with code 0x90..0x9F stages for offset RAM (`ram_sel` = 1). `cmd_addr` gives the start address of the burst.
- R2: A prepare declares a count of (code bits [3:0]) + 1 words, from 1 to 16. A later burst writes at most that many words, to addresses base, base+1, … taken modulo 2^16.
- R3: Data words that arrive after the declared count has been reached are not stored. A data word presented in the same cycle as any command is also dropped.
- R4: Code 0xA2 commits staged offset data and code 0xA4 commits staged coefficient data. A commit is accepted only if its address field is 0x0000 and a prepare is pending.
- R5: If a commit names the other RAM, has a non-zero address, or has no pending prepare, then `cmd_err` pulses in the cycle after the command and no burst starts. The staged words stay readable and unchanged.
- R6: An accepted commit writes only the words received so far. `short_flag` goes to 1 when fewer words were received than declared and to 0 when the counts match. It keeps its value until the next accepted prepare, which clears it.
- R7: An accepted commit raises `busy` and `ram_req` in the next cycle. One word is written in each cycle in which `ram_gnt` is high (`ram_we` = 1). While the grant is low, address and data stay stable. `busy` drops after the last word has been written. A commit with zero received words starts no burst.
- R8: A prepare or commit that arrives while `busy` is high is rejected with a `cmd_err` pulse. The burst in progress still writes its original words.
- R9: An accepted prepare discards all uncommitted staged words. Readback of index 0 then returns 0 until new data arrives.
- R10: Code 0x24 reads staged word number `cmd_addr[3:0]`. `rd_valid` pulses in the next cycle with that word on `rd_data`. An index at or beyond the received count reads as 0.
- R11: While in reset and after it, `busy`, `ram_req`, `ram_we`, `cmd_err`, `short_flag` and `rd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present |
| cmd_code | input | 8 | Command code |
| cmd_addr | input | 16 | Address field of the command |
| data_valid | input | 1 | A data word is present |
| data_word | input | 24 | Data word to stage |
| ram_gnt | input | 1 | Core grants the write port this cycle |
| ram_req | output | 1 | Block requests the write port |
| ram_we | output | 1 | Write strobe to target RAM |
| ram_sel | output | 1 | Target RAM: 0 coefficient, 1 offset |
| ram_addr | output | 16 | Write address |
| ram_wdata | output | 24 | Write data |
| busy | output | 1 | Commit burst in progress |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |
| short_flag | output | 1 | Last commit had fewer words than declared |
| rd_valid | output | 1 | Readback data valid pulse |
| rd_data | output | 24 | Readback word |

## Verification
The bench builds the block with its default parameters: 24-bit words, 16-bit addresses and a 16-entry buffer. With these values every count-nibble value up to the full 16-word burst can be reached, and so can a burst that starts at 0xFFF8 and wraps the address space. A vector table drives matching and mismatching commits, data beyond the declared count, short frames and empty frames. Directed tests then cover a stalled grant, a prepare made during a burst, a prepare that discards staged data, and a commit issued with no pending prepare.

// File: rtl/srw_pkg.sv
// Package: shared types and command codes for the staged RAM writer.
// Assumes commands arrive already decoded into an 8-bit code.
package srw_pkg;

    typedef enum logic {
        SEL_COEF = 1'b0,
        SEL_OFFS = 1'b1
    } ram_sel_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_PREP   = 2'd1,
        OP_COMMIT = 2'd2,
        OP_READ   = 2'd3
    } op_e;

    typedef struct packed {
        op_e      op;
        ram_sel_e tgt;
        logic [3:0] nib;
    } cmd_info_t;

    localparam logic [3:0] PREP_COEF_HI = 4'h8;
    localparam logic [3:0] PREP_OFFS_HI = 4'h9;
    localparam logic [7:0] COMMIT_OFFS  = 8'hA2;
    localparam logic [7:0] COMMIT_COEF  = 8'hA4;
    localparam logic [7:0] READ_STAGED  = 8'h24;

endpackage

// File: rtl/srw_cmd_decode.sv
// Module: classifies an 8-bit command code into operation, target RAM and
// count nibble. Purely combinational; unknown codes map to OP_NONE.
module srw_cmd_decode
    import srw_pkg::*;
(
    input  logic [7:0] code,
    output cmd_info_t  info
);

    // Map the code onto operation and target.
    always_comb begin
        info.op  = OP_NONE;
        info.tgt = SEL_COEF;
        info.nib = code[3:0];
        if (code[7:4] == PREP_COEF_HI) begin
            info.op  = OP_PREP;
            info.tgt = SEL_COEF;
        end else if (code[7:4] == PREP_OFFS_HI) begin
            info.op  = OP_PREP;
            info.tgt = SEL_OFFS;
        end else if (code == COMMIT_OFFS) begin
            info.op  = OP_COMMIT;
            info.tgt = SEL_OFFS;
        end else if (code == COMMIT_COEF) begin
            info.op  = OP_COMMIT;
            info.tgt = SEL_COEF;
        end else if (code == READ_STAGED) begin
            info.op  = OP_READ;
        end
    end

endmodule

// File: rtl/srw_stage_buf.sv
// Module: staging buffer. Holds up to DEPTH words plus target, base
// address, declared and received counts. Assumes load and wr_en are never
// high together (the top gives commands priority over data).
module srw_stage_buf
    import srw_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  ram_sel_e          load_tgt,
    input  logic [ADDR_W-1:0] load_base,
    input  logic [CNT_W-1:0]  load_decl,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lock,
    input  logic              disarm,
    input  logic [IDX_W-1:0]  cidx,
    input  logic [IDX_W-1:0]  ridx,
    output logic              armed,
    output ram_sel_e          tgt,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  declared,
    output logic [CNT_W-1:0]  received,
    output logic [DATA_W-1:0] cdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              accept;

    assign accept = wr_en && armed && !lock && (received < declared);

    // Frame descriptor: captured on prepare, disarmed on accepted commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            tgt      <= SEL_COEF;
            base     <= '0;
            declared <= '0;
            received <= '0;
        end else if (load) begin
            armed    <= 1'b1;
            tgt      <= load_tgt;
            base     <= load_base;
            declared <= load_decl;
            received <= '0;
        end else begin
            if (disarm) armed <= 1'b0;
            if (accept) received <= received + 1'b1;
        end
    end

    // Word storage, one slot per staged word.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[g] <= '0;
                end else if (accept && (received == CNT_W'(g))) begin
                    mem[g] <= wr_data;
                end
            end
        end
    endgenerate

    // Burst read port: indexed directly by the commit sequencer.
    assign cdata = mem[cidx];

    // Readback port: words not yet received read as zero.
    assign rdata = (CNT_W'(ridx) < received) ? mem[ridx] : '0;

endmodule

// File: rtl/srw_commit_seq.sv
// Module: commit burst sequencer. Captures length, base and target at
// start, then writes one word per granted cycle. Assumes start is only
// pulsed while idle.
module srw_commit_seq
    import srw_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_len,
    input  logic [ADDR_W-1:0] start_base,
    input  ram_sel_e          start_tgt,
    input  logic              ram_gnt,
    input  logic [DATA_W-1:0] word_in,
    output logic [IDX_W-1:0]  idx,
    output logic              busy,
    output logic              ram_req,
    output logic              ram_we,
    output logic              ram_sel,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);

    typedef enum logic {SEQ_IDLE = 1'b0, SEQ_BURST = 1'b1} seq_e;

    seq_e              state;
    logic [CNT_W-1:0]  len;
    logic [ADDR_W-1:0] base_q;
    ram_sel_e          tgt_q;
    logic              last;

    assign last = (CNT_W'(idx) == (len - 1'b1));

    // Burst state, index and captured frame parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_IDLE;
            len    <= '0;
            base_q <= '0;
            tgt_q  <= SEL_COEF;
            idx    <= '0;
        end else if (state == SEQ_IDLE) begin
            if (start && (start_len != '0)) begin
                state  <= SEQ_BURST;
                len    <= start_len;
                base_q <= start_base;
                tgt_q  <= start_tgt;
                idx    <= '0;
            end
        end else if (ram_gnt) begin
            if (last) begin
                state <= SEQ_IDLE;
                idx   <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Write-port drive derived from state and grant.
    always_comb begin
        busy      = (state == SEQ_BURST);
        ram_req   = busy;
        ram_we    = busy && ram_gnt;
        ram_sel   = tgt_q;
        ram_addr  = base_q + ADDR_W'(idx);
        ram_wdata = word_in;
    end

endmodule

// File: rtl/staged_ram_writer.sv
// Module: top of the staged runtime RAM writer. Decodes commands, checks
// commit legality, drives the staging buffer and the burst sequencer, and
// registers the error, short-count and readback outputs. Assumes at most
// one command per cycle; a data word in a command cycle is dropped.
module staged_ram_writer
    import srw_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_word,
    input  logic              ram_gnt,
    output logic              ram_req,
    output logic              ram_we,
    output logic              ram_sel,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              busy,
    output logic              cmd_err,
    output logic              short_flag,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    cmd_info_t         info;
    logic              prep_hit, commit_hit, read_hit;
    logic              prep_ok, commit_ok, err_d;
    logic [CNT_W-1:0]  decl_raw, decl_new;
    logic              armed;
    ram_sel_e          st_tgt;
    logic [ADDR_W-1:0] st_base;
    logic [CNT_W-1:0]  st_decl, st_recv;
    logic [DATA_W-1:0] cdata, rdata;
    logic [IDX_W-1:0]  cidx, ridx;

    srw_cmd_decode u_dec (
        .code (cmd_code),
        .info (info)
    );

    // Command qualification and commit legality.
    always_comb begin
        prep_hit   = cmd_valid && (info.op == OP_PREP);
        commit_hit = cmd_valid && (info.op == OP_COMMIT);
        read_hit   = cmd_valid && (info.op == OP_READ);
        decl_raw   = CNT_W'(info.nib) + 1'b1;
        decl_new   = (decl_raw > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : decl_raw;
        prep_ok    = prep_hit && !busy;
        commit_ok  = commit_hit && !busy && armed &&
                     (st_tgt == info.tgt) && (cmd_addr == '0);
        err_d      = (prep_hit && busy) || (commit_hit && !commit_ok);
        ridx       = cmd_addr[IDX_W-1:0];
    end

    srw_stage_buf #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (prep_ok),
        .load_tgt  (info.tgt),
        .load_base (cmd_addr),
        .load_decl (decl_new),
        .wr_en     (data_valid && !cmd_valid),
        .wr_data   (data_word),
        .lock      (busy),
        .disarm    (commit_ok),
        .cidx      (cidx),
        .ridx      (ridx),
        .armed     (armed),
        .tgt       (st_tgt),
        .base      (st_base),
        .declared  (st_decl),
        .received  (st_recv),
        .cdata     (cdata),
        .rdata     (rdata)
    );

    srw_commit_seq #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (commit_ok),
        .start_len  (st_recv),
        .start_base (st_base),
        .start_tgt  (st_tgt),
        .ram_gnt    (ram_gnt),
        .word_in    (cdata),
        .idx        (cidx),
        .busy       (busy),
        .ram_req    (ram_req),
        .ram_we     (ram_we),
        .ram_sel    (ram_sel),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata)
    );

    // Error pulse for any rejected prepare or commit.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_err <= 1'b0;
        else        cmd_err <= err_d;
    end

    // Short-count flag: set by commit, cleared by the next prepare.
    always_ff @(posedge clk) begin
        if (!rst_n)         short_flag <= 1'b0;
        else if (prep_ok)   short_flag <= 1'b0;
        else if (commit_ok) short_flag <= (st_recv < st_decl);
    end

    // Registered readback of one staged word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= read_hit;
            if (read_hit) rd_data <= rdata;
        end
    end

endmodule

// File: rtl/srw_checker.sv
// Module: property checker for staged_ram_writer, attached by bind.
module srw_checker #(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [7:0]        cmd_code,
    input logic              ram_gnt,
    input logic              ram_req,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [DATA_W-1:0] ram_wdata,
    input logic              busy,
    input logic              cmd_err,
    input logic              short_flag,
    input logic              rd_valid
);

    // R7
    we_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_req && ram_gnt));

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (!ram_we || (ram_addr == ADDR_W'($past(ram_addr) + 1'b1))));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && !ram_gnt) |=> (ram_req && $stable(ram_addr) && $stable(ram_wdata)));

    // R8
    busy_prep_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid && (cmd_code[7:5] == 3'b100)) |=> cmd_err);

    // R5
    err_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !$rose(busy));

    // R6
    short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(short_flag));

    // R10
    rd_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && (cmd_code == 8'h24)));

endmodule

bind staged_ram_writer srw_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .ram_gnt    (ram_gnt),
    .ram_req    (ram_req),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .busy       (busy),
    .cmd_err    (cmd_err),
    .short_flag (short_flag),
    .rd_valid   (rd_valid)
);

// File: tb/staged_ram_writer_tb.sv
// Bench: vector table of prepare/data/commit frames, then directed tests.
module staged_ram_writer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    typedef struct packed {
        logic [7:0]  prep;
        logic [15:0] base;
        logic [4:0]  sent;
        logic [7:0]  commit;
        logic [15:0] caddr;
        logic        exp_err;
        logic [4:0]  exp_writes;
        logic        exp_short;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'h80, 16'h0100, 5'd1,  8'hA4, 16'h0000, 1'b0, 5'd1,  1'b0},
        '{8'h83, 16'h0200, 5'd4,  8'hA4, 16'h0000, 1'b0, 5'd4,  1'b0},
        '{8'h9F, 16'hFFF8, 5'd16, 8'hA2, 16'h0000, 1'b0, 5'd16, 1'b0},
        '{8'h92, 16'h0040, 5'd6,  8'hA2, 16'h0000, 1'b0, 5'd3,  1'b0},
        '{8'h87, 16'h0300, 5'd5,  8'hA4, 16'h0000, 1'b0, 5'd5,  1'b1},
        '{8'h81, 16'h0010, 5'd2,  8'hA2, 16'h0000, 1'b1, 5'd0,  1'b0},
        '{8'h95, 16'h0020, 5'd6,  8'hA2, 16'h0004, 1'b1, 5'd0,  1'b0},
        '{8'h8F, 16'h1000, 5'd0,  8'hA4, 16'h0000, 1'b0, 5'd0,  1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic [15:0] cmd_addr = '0;
    logic        data_valid = 1'b0;
    logic [23:0] data_word = '0;
    logic        ram_gnt = 1'b1;
    logic        ram_req, ram_we, ram_sel, busy, cmd_err, short_flag, rd_valid;
    logic [15:0] ram_addr;
    logic [23:0] ram_wdata, rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    staged_ram_writer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .cmd_addr   (cmd_addr),
        .data_valid (data_valid),
        .data_word  (data_word),
        .ram_gnt    (ram_gnt),
        .ram_req    (ram_req),
        .ram_we     (ram_we),
        .ram_sel    (ram_sel),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .busy       (busy),
        .cmd_err    (cmd_err),
        .short_flag (short_flag),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    function automatic logic [23:0] word_of(int v, int i);
        return 24'h5A0000 + 24'(v) * 24'h001000 + 24'(i) * 24'h000101;
    endfunction

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_cmd(logic [7:0] code, logic [15:0] addr);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_addr  = addr;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_data(logic [23:0] w);
        @(negedge clk);
        data_valid = 1'b1;
        data_word  = w;
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    task automatic read_word(string req, int idx, logic [23:0] exp);
        send_cmd(8'h24, 16'(idx));
        check_eq(req, {31'd0, rd_valid}, 32'd1);
        check_eq(req, {8'd0, rd_data}, {8'd0, exp});
    endtask

    // Collect a burst with grant high; checks address, data and target.
    task automatic collect(string req, int v, logic [15:0] base, logic sel, output int n);
        n = 0;
        for (int guard = 0; guard < 40 && busy; guard++) begin
            if (ram_we) begin
                check_eq(req, {16'd0, ram_addr}, {16'd0, 16'(base + 16'(n))});
                check_eq(req, {8'd0, ram_wdata}, {8'd0, word_of(v, n)});
                check_eq(req, {31'd0, ram_sel}, {31'd0, sel});
                n++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        // R11: reset state
        repeat (3) @(negedge clk);
        check_eq("R11 reset outputs",
                 {26'd0, busy, ram_req, ram_we, cmd_err, short_flag, rd_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R11 after reset",
                 {26'd0, busy, ram_req, ram_we, cmd_err, short_flag, rd_valid}, 32'd0);

        // Vector table: R1 R2 R3 R4 R5 R6 R10
        for (int v = 0; v < NV; v++) begin
            automatic vec_t t = VECS[v];
            automatic int decl = int'(t.prep[3:0]) + 1;
            send_cmd(t.prep, t.base);
            check_eq("R1 prepare accepted", {31'd0, cmd_err}, 32'd0);
            for (int i = 0; i < int'(t.sent); i++) send_data(word_of(v, i));
            if (t.sent != 0) read_word("R10 readback word 0", 0, word_of(v, 0));
            if (int'(t.exp_writes) < 16 && !t.exp_err)
                read_word("R3 unreceived slot reads zero", int'(t.exp_writes), 24'd0);
            send_cmd(t.commit, t.caddr);
            check_eq("R4 R5 commit error", {31'd0, cmd_err}, {31'd0, t.exp_err});
            collect("R1 R2 burst word", v, t.base, t.prep[4], n);
            check_eq("R2 R3 write count", 32'(n), 32'(t.exp_writes));
            if (t.exp_err) begin
                read_word("R5 buffer kept", 0, word_of(v, 0));
            end else begin
                check_eq("R6 short flag", {31'd0, short_flag}, {31'd0, t.exp_short});
                check_eq("R6 short vs count", {31'd0, short_flag},
                         {31'd0, (int'(t.sent) < decl)});
            end
        end

        // R7 R8: stalled grant, prepare during burst rejected
        send_cmd(8'h81, 16'h0500);
        send_data(word_of(20, 0));
        send_data(word_of(20, 1));
        @(negedge clk);
        ram_gnt = 1'b0;
        send_cmd(8'hA4, 16'h0000);
        for (int k = 0; k < 3; k++) begin
            check_eq("R7 stalled request", {29'd0, busy, ram_req, ram_we}, 32'b110);
            @(negedge clk);
        end
        send_cmd(8'h90, 16'h0700);
        check_eq("R8 prepare while busy", {31'd0, cmd_err}, 32'd1);
        send_cmd(8'hA4, 16'h0000);
        check_eq("R8 commit while busy", {31'd0, cmd_err}, 32'd1);
        check_eq("R7 address held", {16'd0, ram_addr}, 32'h0500);
        ram_gnt = 1'b1;
        #1;
        collect("R7 granted burst", 20, 16'h0500, 1'b0, n);
        check_eq("R7 R8 burst count", 32'(n), 32'd2);
        check_eq("R7 busy cleared", {31'd0, busy}, 32'd0);

        // R4 R5: commit with no pending prepare
        send_cmd(8'hA4, 16'h0000);
        check_eq("R4 commit without prepare", {31'd0, cmd_err}, 32'd1);
        check_eq("R5 no burst", {31'd0, busy}, 32'd0);

        // R9: new prepare discards staged words
        send_cmd(8'h83, 16'h0600);
        send_data(word_of(21, 0));
        send_data(word_of(21, 1));
        send_cmd(8'h80, 16'h0680);
        read_word("R9 discarded word", 0, 24'd0);
        send_cmd(8'hA4, 16'h0000);
        check_eq("R9 empty commit ok", {31'd0, cmd_err}, 32'd0);
        check_eq("R9 no burst after discard", {31'd0, busy}, 32'd0);
        check_eq("R9 short after discard", {31'd0, short_flag}, 32'd1);

        // R3: data word in a command cycle is dropped
        send_cmd(8'h81, 16'h0800);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 8'h24; cmd_addr = 16'h0000;
        data_valid = 1'b1; data_word = 24'hABCDEF;
        @(negedge clk);
        cmd_valid = 1'b0; data_valid = 1'b0;
        read_word("R3 data with command dropped", 0, 24'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule